// File: doc/BRIEF.md
# Cascaded Switch Array Loader

This block sits on the host side of a chain of serially loaded 16-channel switch devices. Each device holds a 16-stage shift register that feeds a bank of transparent latches, and the devices are daisy-chained so that data leaving the last stage of one device enters the next. The loader takes a parallel pattern of `NUM_DEV*CH_PER_DEV` bits and a one-cycle `start` strobe. It then produces the serial data line, the shift clock, an active-low latch strobe and a clear line for the chain. When the new pattern has been captured it raises `done` for one cycle.

The shift clock is derived from the system clock. Each phase lasts a whole number of system cycles, computed at elaboration so that the clock never goes faster than `SCLK_MAX_HZ`. The latch strobe stays inactive (high) for the whole shift, so clock feedthrough does not disturb the switches while bits travel through the chain. Once the last bit is in, the loader waits a programmable setup interval, drives the latch strobe low for a programmable width, and releases it. A separate request from idle issues a clear pulse of programmable width. The clear pulse is never issued during a shift.

Top module: `swchain_loader`

## Requirements
- R1: A load produces exactly `NUM_DEV*CH_PER_DEV` rising edges of `ser_clk`. A clear pulse produces none.
- R2: Bits leave on `ser_data` from `pattern[NUM_DEV*CH_PER_DEV-1]` down to `pattern[0]`. After the latch pulse, device k (k=0 is the device wired directly to the loader) holds `pattern[k*CH_PER_DEV +: CH_PER_DEV]`, and bit j of that slice sits in stage j.
- R3: Every high phase and every low phase of `ser_clk` during a shift lasts exactly HALF system cycles, where HALF = ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ)), which is 4 with the defaults. The first low phase starts in the cycle after `start` is sampled. `ser_data` changes only when `ser_clk` falls, so it is stable in every cycle in which `ser_clk` is high.
- R4: `latch_n` stays high through the whole shift. It goes low exactly `SETUP_CYC` cycles after the last falling edge of `ser_clk`, stays low for exactly `LATCH_CYC` cycles, then returns high. The devices' outputs keep the previous pattern until this pulse.
- R5: `busy` is high from the cycle after `start` is sampled until the `done` cycle, inclusive. That is 2*HALF*N*16 + SETUP_CYC + LATCH_CYC + 1 cycles. `done` is high for exactly one cycle, in the cycle right after `latch_n` returns high, and `busy` is low in the next cycle.
- R6: A `start` that arrives while `busy` is high is ignored. A change of `pattern` after the accepted `start` has no effect on the loaded data.
- R7: A `clear_req` sampled while idle drives `sw_clear` high for exactly `CLEAR_CYC` cycles. During that pulse `ser_clk` is low, `latch_n` is high and `busy` is high, and no `done` is given. If `start` and `clear_req` arrive in the same idle cycle, `start` wins and the clear is dropped.
- R8: A `clear_req` that arrives while `busy` is high is ignored, so `sw_clear` is never high during a shift.
- R9: After reset, `ser_clk`=0, `latch_n`=1, `sw_clear`=0, `busy`=0, `done`=0 and `ser_data`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to load `pattern` |
| clear_req | input | 1 | One-cycle request for a clear pulse |
| pattern | input | NUM_DEV*CH_PER_DEV | Switch pattern; slice k goes to device k |
| ser_data | output | 1 | Serial data to the first device of the chain |
| ser_clk | output | 1 | Shift clock; devices sample on its rising edge |
| latch_n | output | 1 | Active-low latch strobe |
| sw_clear | output | 1 | Active-high clear of the device latches |
| busy | output | 1 | A load or clear sequence is in progress |
| done | output | 1 | One-cycle pulse when a load has been latched |

## Verification
The hardest case to reach from the ports is a request that lands in the middle of a shift: a second `start`, a `clear_req` and a changed `pattern` all arriving while bits are still moving through the chain. A directed variant of the load task waits a fixed number of cycles into the shift and then asserts all three together. The bench's model of the device chain must still capture the original pattern, with no extra clock edges and no clear. Random patterns drawn from a seeded `$urandom` are combined with all-zero, all-one and single-bit patterns, so that a swapped bit order or an off-by-one in the bit count shows up in a particular device slice.

// File: rtl/swl_pkg.sv
package swl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_SHIFT_LO = 3'd1,
      ST_SHIFT_HI = 3'd2,
      ST_SETUP    = 3'd3,
      ST_LATCH    = 3'd4,
      ST_DONE     = 3'd5,
      ST_CLEAR    = 3'd6
   } swl_state_e;

   function automatic int unsigned swl_ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned swl_max4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/swl_timer.sv
module swl_timer #(
   parameter int unsigned TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);

   logic [TW-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count <= '0;
      else if (load)           count <= load_val;
      else if (count != '0)    count <= count - 1'b1;
   end

   assign expired = (count == '0);

endmodule

// File: rtl/swl_shifter.sv
module swl_shifter #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic [WIDTH-1:0] par_in,
   output logic             msb
);

   generate
      if (WIDTH == 1) begin : g_single
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    bit_q <= 1'b0;
            else if (load) bit_q <= par_in[0];
         end
         assign msb = bit_q;
      end else begin : g_multi
         logic [WIDTH-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sr <= '0;
            else if (load)  sr <= par_in;
            else if (shift) sr <= {sr[WIDTH-2:0], 1'b0};
         end
         assign msb = sr[WIDTH-1];
      end
   endgenerate

   // Sequencer must never request both operations together (R2 ordering)
   p_load_shift_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));

endmodule

// File: rtl/swl_seq.sv
module swl_seq
   import swl_pkg::*;
#(
   parameter int unsigned TOTAL     = 32,
   parameter int unsigned HALF      = 4,
   parameter int unsigned SETUP_CYC = 3,
   parameter int unsigned LATCH_CYC = 4,
   parameter int unsigned CLEAR_CYC = 5,
   parameter int unsigned TW        = 4,
   parameter int unsigned BW        = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          clear_req,
   input  logic          tmr_zero,
   output logic          tmr_load,
   output logic [TW-1:0] tmr_val,
   output logic          sh_load,
   output logic          sh_shift,
   output logic          sclk_o,
   output logic          latch_n_o,
   output logic          clr_o,
   output logic          busy_o,
   output logic          done_o
);

   swl_state_e    state, nxt;
   logic [BW-1:0] bits_left;
   logic          bit_ld, bit_dec;

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      bit_ld   = 1'b0;
      bit_dec  = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               nxt      = ST_SHIFT_LO;
               tmr_load = 1'b1;
               tmr_val  = TW'(HALF - 1);
               sh_load  = 1'b1;
               bit_ld   = 1'b1;
            end else if (clear_req) begin
               nxt      = ST_CLEAR;
               tmr_load = 1'b1;
               tmr_val  = TW'(CLEAR_CYC - 1);
            end
         end
         ST_SHIFT_LO: begin
            if (tmr_zero) begin
               nxt      = ST_SHIFT_HI;
               tmr_load = 1'b1;
               tmr_val  = TW'(HALF - 1);
            end
         end
         ST_SHIFT_HI: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               if (bits_left == '0) begin
                  nxt     = ST_SETUP;
                  tmr_val = TW'(SETUP_CYC - 1);
               end else begin
                  nxt      = ST_SHIFT_LO;
                  tmr_val  = TW'(HALF - 1);
                  sh_shift = 1'b1;
                  bit_dec  = 1'b1;
               end
            end
         end
         ST_SETUP: begin
            if (tmr_zero) begin
               nxt      = ST_LATCH;
               tmr_load = 1'b1;
               tmr_val  = TW'(LATCH_CYC - 1);
            end
         end
         ST_LATCH: if (tmr_zero) nxt = ST_DONE;
         ST_DONE:  nxt = ST_IDLE;
         ST_CLEAR: if (tmr_zero) nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bits_left <= '0;
         sclk_o    <= 1'b0;
         latch_n_o <= 1'b1;
         clr_o     <= 1'b0;
         busy_o    <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         state <= nxt;
         if (bit_ld)       bits_left <= BW'(TOTAL - 1);
         else if (bit_dec) bits_left <= bits_left - 1'b1;
         sclk_o    <= (nxt == ST_SHIFT_HI);
         latch_n_o <= (nxt != ST_LATCH);
         clr_o     <= (nxt == ST_CLEAR);
         busy_o    <= (nxt != ST_IDLE);
         done_o    <= (nxt == ST_DONE);
      end
   end

   // A request while busy must not restart the sequence (R6, R8)
   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT_HI && !tmr_zero) |=> (state == ST_SHIFT_HI));

   p_clear_only_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CLEAR) |-> ($past(state) == ST_IDLE || $past(state) == ST_CLEAR));

endmodule

// File: rtl/swchain_loader.sv
module swchain_loader
   import swl_pkg::*;
#(
   parameter int unsigned NUM_DEV     = 2,
   parameter int unsigned CH_PER_DEV  = 16,
   parameter int unsigned SYS_CLK_HZ  = 125_000_000,
   parameter int unsigned SCLK_MAX_HZ = 20_000_000,
   parameter int unsigned SETUP_CYC   = 3,
   parameter int unsigned LATCH_CYC   = 4,
   parameter int unsigned CLEAR_CYC   = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          clear_req,
   input  logic [NUM_DEV*CH_PER_DEV-1:0] pattern,
   output logic                          ser_data,
   output logic                          ser_clk,
   output logic                          latch_n,
   output logic                          sw_clear,
   output logic                          busy,
   output logic                          done
);

   localparam int unsigned TOTAL = NUM_DEV * CH_PER_DEV;
   localparam int unsigned HALF  = swl_ceil_div(SYS_CLK_HZ, 2 * SCLK_MAX_HZ);
   localparam int unsigned TMAX  = swl_max4(HALF, SETUP_CYC, LATCH_CYC, CLEAR_CYC);
   localparam int unsigned TW    = $clog2(TMAX + 1);
   localparam int unsigned BW    = $clog2(TOTAL + 1);
   localparam int unsigned LW    = $clog2(swl_max4(SETUP_CYC, LATCH_CYC, 1, 1) + 1);

   generate
      if (NUM_DEV < 1)      begin : g_bad_dev   $error("NUM_DEV must be at least 1"); end
      if (CH_PER_DEV < 1)   begin : g_bad_ch    $error("CH_PER_DEV must be at least 1"); end
      if (SCLK_MAX_HZ == 0) begin : g_bad_sclk  $error("SCLK_MAX_HZ must be nonzero"); end
      if (HALF < 1)         begin : g_bad_half  $error("derived clock phase is empty"); end
      if (SETUP_CYC < 1 || LATCH_CYC < 1 || CLEAR_CYC < 1) begin : g_bad_width
         $error("pulse widths must be at least one cycle");
      end
   endgenerate

   logic          tmr_load, tmr_zero, sh_load, sh_shift;
   logic [TW-1:0] tmr_val;

   swl_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
   );

   swl_shifter #(.WIDTH(TOTAL)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .shift(sh_shift),
      .par_in(pattern), .msb(ser_data)
   );

   swl_seq #(
      .TOTAL(TOTAL), .HALF(HALF), .SETUP_CYC(SETUP_CYC), .LATCH_CYC(LATCH_CYC),
      .CLEAR_CYC(CLEAR_CYC), .TW(TW), .BW(BW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .clear_req(clear_req),
      .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
      .sh_load(sh_load), .sh_shift(sh_shift),
      .sclk_o(ser_clk), .latch_n_o(latch_n), .clr_o(sw_clear),
      .busy_o(busy), .done_o(done)
   );

   // Observation counters used only by the properties below
   logic          sclk_q;
   logic [BW-1:0] rise_cnt;
   logic [LW-1:0] low_run, latch_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         rise_cnt  <= '0;
         low_run   <= '0;
         latch_run <= '0;
      end else begin
         sclk_q <= ser_clk;
         if (!busy)                 rise_cnt <= '0;
         else if (ser_clk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
         if (ser_clk || !latch_n)   low_run <= '0;
         else if (low_run < LW'(SETUP_CYC)) low_run <= low_run + 1'b1;
         if (latch_n)               latch_run <= '0;
         else if (latch_run < LW'(LATCH_CYC)) latch_run <= latch_run + 1'b1;
      end
   end

   p_bits_per_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rise_cnt == BW'(TOTAL)));

   p_data_stable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> $stable(ser_data));

   p_setup_before_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latch_n) |-> (low_run == LW'(SETUP_CYC)));

   p_latch_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_n) |-> (latch_run == LW'(LATCH_CYC)));

   p_latch_quiet_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_n |-> (!ser_clk && !sw_clear));

   p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy && !done);

   p_busy_needs_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(start) || $past(clear_req)));

   p_clear_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clear |-> (!ser_clk && latch_n && busy && !done));

endmodule

// File: tb/tb_swchain_loader.sv
module tb_swchain_loader;

   localparam int NDEV  = 2;
   localparam int NCH   = 16;
   localparam int TOT   = NDEV * NCH;
   localparam int SYSHZ = 125_000_000;
   localparam int MAXHZ = 20_000_000;
   localparam int SETUP = 3;
   localparam int LEW   = 4;
   localparam int CLRW  = 5;
   localparam int HALF  = (SYSHZ + 2 * MAXHZ - 1) / (2 * MAXHZ);
   localparam int LOAD_BUSY = 2 * HALF * TOT + SETUP + LEW + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic clear_req = 1'b0;
   logic [TOT-1:0] pattern = '0;
   logic ser_data, ser_clk, latch_n, sw_clear, busy, done;

   always #4 clk = ~clk;

   swchain_loader #(
      .NUM_DEV(NDEV), .CH_PER_DEV(NCH), .SYS_CLK_HZ(SYSHZ), .SCLK_MAX_HZ(MAXHZ),
      .SETUP_CYC(SETUP), .LATCH_CYC(LEW), .CLEAR_CYC(CLRW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .clear_req(clear_req), .pattern(pattern),
      .ser_data(ser_data), .ser_clk(ser_clk), .latch_n(latch_n), .sw_clear(sw_clear),
      .busy(busy), .done(done)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Behavioural chain of register/latch devices plus port measurements
   logic [TOT-1:0] chain_sr = '0, chain_lat = '0, pre_lat = '0;
   logic prev_clk = 0, prev_data = 0, prev_latch = 1, prev_clr = 0;
   int n_rise, hi_run, hi_min, hi_max, lo_run, lo_min, lo_max;
   int setup_seen, le_run, le_w, clr_run, clr_w, clr_bad, done_n, busy_n, data_chg, le_early;

   task automatic clear_stats();
      n_rise = 0; hi_run = 0; hi_min = 1 << 30; hi_max = 0;
      lo_run = 0; lo_min = 1 << 30; lo_max = 0;
      setup_seen = -1; le_run = 0; le_w = -1; clr_run = 0; clr_w = -1; clr_bad = 0;
      done_n = 0; busy_n = 0; data_chg = 0; le_early = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) busy_n++;
         if (done) done_n++;
         if (ser_clk) begin
            if (!prev_clk) begin
               n_rise++;
               chain_sr = {chain_sr[TOT-2:0], ser_data};
               if (lo_run < lo_min) lo_min = lo_run;
               if (lo_run > lo_max) lo_max = lo_run;
               lo_run = 0;
               hi_run = 0;
            end else if (ser_data != prev_data) begin
               data_chg++;
            end
            hi_run++;
         end else begin
            if (prev_clk) begin
               if (hi_run < hi_min) hi_min = hi_run;
               if (hi_run > hi_max) hi_max = hi_run;
            end
            if (busy && latch_n && !sw_clear) lo_run++;
         end
         if (!latch_n) begin
            if (prev_latch) begin
               setup_seen = lo_run;
               pre_lat = chain_lat;
               le_run = 0;
               if (n_rise != TOT) le_early++;
            end
            le_run++;
         end else if (!prev_latch) begin
            le_w = le_run;
         end
         if (sw_clear) begin
            if (!prev_clr) clr_run = 0;
            clr_run++;
            if (ser_clk || !latch_n) clr_bad++;
         end else if (prev_clr) begin
            clr_w = clr_run;
         end
         if (sw_clear) chain_lat = '0;
         else if (!latch_n) chain_lat = chain_sr;
         prev_clk = ser_clk; prev_data = ser_data; prev_latch = latch_n; prev_clr = sw_clear;
      end
   end

   task automatic run_load(input logic [TOT-1:0] pat, input bit inject);
      logic [TOT-1:0] old_lat;
      old_lat = chain_lat;
      @(posedge clk);
      clear_stats();
      @(negedge clk);
      pattern = pat;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (inject) begin
         repeat (40) @(negedge clk);
         start = 1'b1; clear_req = 1'b1; pattern = ~pat;
         @(negedge clk);
         start = 1'b0; clear_req = 1'b0;
      end
      while (!done) @(negedge clk);
      repeat (12) @(negedge clk);
      pattern = '0;
      chk("R1", "rising shift edges", n_rise, TOT);
      chk("R3", "shortest high phase", hi_min, HALF);
      chk("R3", "longest high phase", hi_max, HALF);
      chk("R3", "shortest low phase", lo_min, HALF);
      chk("R3", "longest low phase", lo_max, HALF);
      chk("R3", "data changes while clock high", data_chg, 0);
      chk("R4", "setup cycles before latch", setup_seen, SETUP);
      chk("R4", "latch pulse width", le_w, LEW);
      chk("R4", "latch low before last bit", le_early, 0);
      chk("R4", "outputs held until latch", (pre_lat == old_lat), 1);
      chk("R5", "busy cycles", busy_n, LOAD_BUSY);
      chk("R5", "done pulses", done_n, 1);
      chk("R8", "clear pulses during load", clr_w, -1);
      for (int d = 0; d < NDEV; d++)
         chk("R2", $sformatf("device %0d slice", d),
             chain_lat[d*NCH +: NCH], pat[d*NCH +: NCH]);
      if (inject) chk("R6", "pattern after ignored start", chain_lat, pat);
   endtask

   task automatic run_clear();
      @(posedge clk);
      clear_stats();
      @(negedge clk);
      clear_req = 1'b1;
      @(negedge clk);
      clear_req = 1'b0;
      repeat (CLRW + 8) @(negedge clk);
      chk("R7", "clear width", clr_w, CLRW);
      chk("R7", "clock or latch during clear", clr_bad, 0);
      chk("R7", "busy cycles of clear", busy_n, CLRW);
      chk("R7", "done during clear", done_n, 0);
      chk("R1", "shift edges during clear", n_rise, 0);
      chk("R7", "device outputs cleared", chain_lat, 0);
   endtask

   function automatic logic [TOT-1:0] rand_pat();
      logic [TOT-1:0] p;
      for (int i = 0; i < TOT; i += 32) p = (p << 32) | TOT'($urandom());
      return p;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      clear_stats();
      repeat (3) @(negedge clk);
      chk("R9", "ser_clk in reset", ser_clk, 0);
      chk("R9", "latch_n in reset", latch_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "ser_clk after reset", ser_clk, 0);
      chk("R9", "latch_n after reset", latch_n, 1);
      chk("R9", "sw_clear after reset", sw_clear, 0);
      chk("R9", "busy after reset", busy, 0);
      chk("R9", "done after reset", done, 0);
      chk("R9", "ser_data after reset", ser_data, 0);

      run_load('1, 0);
      run_load('0, 0);
      run_load(TOT'(1) << (TOT - 1), 0);
      run_load(TOT'(1), 0);
      run_load({(TOT/2){2'b10}}, 0);
      run_load(rand_pat(), 1);
      run_clear();
      for (int n = 0; n < 6; n++) run_load(rand_pat(), 0);
      run_clear();

      // start and clear together in idle: the load wins (R7)
      @(posedge clk);
      clear_stats();
      @(negedge clk);
      pattern = 32'h1234_A5C3;
      start = 1'b1; clear_req = 1'b1;
      @(negedge clk);
      start = 1'b0; clear_req = 1'b0;
      while (!done) @(negedge clk);
      repeat (10) @(negedge clk);
      chk("R7", "clear when start has priority", clr_w, -1);
      chk("R2", "pattern under start priority", chain_lat, 32'h1234_A5C3);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule